// File: doc/BRIEF.md
# 10 Mb/s Manchester Line Transmitter with Management Port

This block is the transmit half of a 10 Mb/s Ethernet physical layer. A MAC hands it frame data as two-bit symbols over an RMII transmit interface (`tx_en` plus a dibit) clocked by the reference clock. The block samples each dibit once, emits its two bits least significant first at 10 Mb/s, Manchester-codes them and drives the result on a complementary pair of logic outputs standing in for the differential line.

A serial management slave (MDC/MDIO framing) sits beside the datapath. Through it software can turn on a loopback mode, which sends the coded stream to a separate loopback output and parks the line, or a bypass mode, which places the raw, uncoded bits on the line. A new mode is picked up only while no frame is being sent.

The RMII side has no ready signal. By the rules of that interface the sink cannot push back: the MAC must hold each dibit for exactly `DIBIT_CYC` reference cycles while `tx_en` is high, and the block always accepts it. The management port is a plain serial register port.

Top module: `eth10_tx_phy`

## Requirements
- R1: After reset `line_p` is 0, `line_n` is 1, `lpbk_out` is 0 and `mdio_oe` is 0.
- R2: While idle, a high `tx_en` at a clock edge starts a frame and captures `txd` at that edge. Each further dibit is captured `DIBIT_CYC` (10) edges later, as long as `tx_en` is still high. Bit 0 of a dibit goes out before bit 1.
- R3: Each bit lasts 5 cycles: 3 cycles of first half, then 2 of second half. In normal mode a 1 is sent as low then high, and a 0 as high then low. The cycle that shows phase p of a frame is the one after edge p+1, counting the start edge as edge 0.
- R4: `line_n` is the complement of `line_p` in every cycle.
- R5: A frame ends when `tx_en` is low at a dibit boundary. From the next cycle on, `line_p` and `lpbk_out` stay at 0.
- R6: A management write is a preamble of at least 32 ones, start bits 0 then 1, opcode 01, a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all sent MSB first and sampled on rising MDC. If the PHY address equals `phy_addr`, the write takes effect. Register 0 bit 14 sets loopback and register 16 bit 0 sets bypass.
- R7: A read uses opcode 10 and the same framing. The block keeps `mdio_oe` low through the first turnaround bit. It drives 0 for the second turnaround bit and then the 16 data bits MSB first, and releases the line after the last one. Bits that are not implemented, and registers that are not implemented, read as 0.
- R8: A frame whose PHY address differs from `phy_addr` changes no register and never raises `mdio_oe`.
- R9: In loopback the line stays at `line_p`=0 and `lpbk_out` carries the stream the line would have carried. Outside loopback `lpbk_out` is 0.
- R10: In bypass the stream is the raw bit, held for all 5 cycles of its bit time.
- R11: A mode written during a frame does not affect that frame. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | RMII transmit enable |
| txd | input | 2 | RMII transmit dibit |
| phy_addr | input | 5 | Strapped management address |
| mdc | input | 1 | Management clock, oversampled by clk |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| line_p | output | 1 | Positive line output |
| line_n | output | 1 | Negative line output |
| lpbk_out | output | 1 | Loopback copy of the coded stream |

## Verification
The hardest case to reach is a mode register changing in the middle of a frame. A management frame takes over a thousand reference cycles, so the bench forks a long transmit frame of about 120 dibits and runs a bypass-clearing write alongside it. The frame checker expects the old mode up to the last cycle, and the next frame expects the new one. Random dibit patterns and frame lengths from a fixed seed cover the coding of both bit values in both bit slots.

// File: rtl/eth10_pkg.sv
package eth10_pkg;

  typedef struct packed {
    logic loop;
    logic bypass;
  } tx_mode_t;

  typedef enum logic [2:0] {
    MS_PRE,
    MS_START,
    MS_HDR,
    MS_TA,
    MS_DATA
  } mdio_state_t;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

endpackage

// File: rtl/eth10_mdio_slave.sv
module eth10_mdio_slave
  import eth10_pkg::*;
#(
  parameter int PRE_BITS   = 32,
  parameter int SYNC_DEPTH = 2,
  parameter int CTRL_REG   = 0,
  parameter int LOOP_BIT   = 14,
  parameter int VEND_REG   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] phy_addr,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  output tx_mode_t   cfg
);

  localparam int PCW = $clog2(PRE_BITS + 1);

  logic [SYNC_DEPTH:0]   mdc_sh;
  logic [SYNC_DEPTH-1:0] dat_sh;

  // oversampling synchronizers; data and clock see equal delay
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_DEPTH; gi++) begin : g_mdc_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_sh[gi] <= 1'b0;
        else if (gi == 0) mdc_sh[gi] <= mdc;
        else mdc_sh[gi] <= mdc_sh[gi-1];
      end
    end
    for (gi = 0; gi < SYNC_DEPTH; gi++) begin : g_dat_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dat_sh[gi] <= 1'b0;
        else if (gi == 0) dat_sh[gi] <= mdio_i;
        else dat_sh[gi] <= dat_sh[gi-1];
      end
    end
  endgenerate

  logic rise, sbit;
  assign rise = mdc_sh[SYNC_DEPTH-1] & ~mdc_sh[SYNC_DEPTH];
  assign sbit = dat_sh[SYNC_DEPTH-1];

  mdio_state_t st_q;
  logic [PCW-1:0] pre_q;
  logic [3:0]     cnt_q;
  logic [10:0]    hdr_q;
  logic [4:0]     reg_q;
  logic           rd_q, wr_q;
  logic [15:0]    sh_q;
  logic           oe_q, o_q;
  logic           loop_q, byp_q;

  logic [11:0] hdr_full;
  logic        addr_hit;
  logic [15:0] rd_val;
  assign hdr_full = {hdr_q, sbit};
  assign addr_hit = (hdr_full[9:5] == phy_addr);

  always_comb begin
    rd_val = '0;
    if (reg_q == 5'(CTRL_REG)) rd_val[LOOP_BIT] = loop_q;
    else if (reg_q == 5'(VEND_REG)) rd_val[0] = byp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_PRE;
      pre_q  <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      reg_q  <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      loop_q <= 1'b0;
      byp_q  <= 1'b0;
    end else if (rise) begin
      case (st_q)
        MS_PRE: begin
          if (sbit) begin
            if (pre_q < PCW'(PRE_BITS)) pre_q <= pre_q + 1'b1;
          end else begin
            if (pre_q >= PCW'(PRE_BITS)) st_q <= MS_START;
            pre_q <= '0;
          end
        end
        MS_START: begin
          st_q  <= sbit ? MS_HDR : MS_PRE;
          cnt_q <= '0;
        end
        MS_HDR: begin
          hdr_q <= hdr_full[10:0];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd11) begin
            reg_q <= hdr_full[4:0];
            rd_q  <= (hdr_full[11:10] == OP_READ)  && addr_hit;
            wr_q  <= (hdr_full[11:10] == OP_WRITE) && addr_hit;
            cnt_q <= '0;
            if (hdr_full[11:10] == OP_READ || hdr_full[11:10] == OP_WRITE)
              st_q <= MS_TA;
            else
              st_q <= MS_PRE;
          end
        end
        MS_TA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd0) begin
            if (rd_q) begin
              oe_q <= 1'b1;
              o_q  <= 1'b0;
            end
          end else begin
            cnt_q <= '0;
            st_q  <= MS_DATA;
            if (rd_q) begin
              o_q  <= rd_val[15];
              sh_q <= {rd_val[14:0], 1'b0};
            end
          end
        end
        MS_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (rd_q) begin
            o_q  <= sh_q[15];
            sh_q <= {sh_q[14:0], 1'b0};
          end else begin
            sh_q <= {sh_q[14:0], sbit};
          end
          if (cnt_q == 4'd15) begin
            oe_q  <= 1'b0;
            st_q  <= MS_PRE;
            pre_q <= '0;
            cnt_q <= '0;
            if (wr_q) begin
              if (reg_q == 5'(CTRL_REG)) loop_q <= sh_q[LOOP_BIT-1];
              if (reg_q == 5'(VEND_REG)) byp_q  <= sbit;
            end
          end
        end
        default: st_q <= MS_PRE;
      endcase
    end
  end

  assign mdio_o     = o_q;
  assign mdio_oe    = oe_q;
  assign cfg.loop   = loop_q;
  assign cfg.bypass = byp_q;

  // R7: output enable only inside the turnaround/data part of a frame
  a_r7_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> ((st_q == MS_TA || st_q == MS_DATA) && rd_q));

  // R6: configuration only moves on a sampled MDC rise
  a_r6_cfg_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(loop_q) && $stable(byp_q)));

  // R8: a frame for another address never drives
  a_r8_no_foreign_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_DATA && !rd_q) |-> !oe_q);

endmodule

// File: rtl/eth10_serializer.sv
module eth10_serializer #(
  parameter int DIBIT_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic [1:0] txd,
  output logic       active,
  output logic       bit_val,
  output logic       first_half
);

  localparam int PW      = $clog2(DIBIT_CYC);
  localparam int BIT_CYC = DIBIT_CYC / 2;
  localparam int H1_CYC  = (BIT_CYC + 1) / 2;

  logic          act_q;
  logic [PW-1:0] ph_q;
  logic [1:0]    dib_q;
  logic          last_ph;

  assign last_ph = (ph_q == PW'(DIBIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      dib_q <= '0;
    end else if (!act_q || last_ph) begin
      act_q <= tx_en;
      ph_q  <= '0;
      if (tx_en) dib_q <= txd;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  logic          hi_bit;
  logic [PW-1:0] sub;
  assign hi_bit     = (ph_q >= PW'(BIT_CYC));
  assign sub        = hi_bit ? ph_q - PW'(BIT_CYC) : ph_q;
  assign bit_val    = hi_bit ? dib_q[1] : dib_q[0];
  assign first_half = (sub < PW'(H1_CYC));
  assign active     = act_q;

  // R2: phase counter stays inside one dibit period
  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (ph_q < PW'(DIBIT_CYC)));

  // R2: the captured dibit is held until the period boundary
  a_r2_dibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_ph) |=> $stable(dib_q));

endmodule

// File: rtl/eth10_line_encoder.sv
module eth10_line_encoder
  import eth10_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_en,
  input  logic     active,
  input  logic     bit_val,
  input  logic     first_half,
  input  tx_mode_t cfg,
  output logic     line_p,
  output logic     line_n,
  output logic     lpbk_out
);

  tx_mode_t mode_q;
  logic     p_q, n_q, lb_q;
  logic     stream;

  // mode is taken over only between frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (!active && !tx_en) mode_q <= cfg;
  end

  always_comb begin
    if (!active) stream = 1'b0;
    else if (mode_q.bypass) stream = bit_val;
    else stream = first_half ? ~bit_val : bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= 1'b0;
      n_q  <= 1'b1;
      lb_q <= 1'b0;
    end else begin
      p_q  <= mode_q.loop ? 1'b0 : stream;
      n_q  <= mode_q.loop ? 1'b1 : ~stream;
      lb_q <= mode_q.loop ? stream : 1'b0;
    end
  end

  assign line_p   = p_q;
  assign line_n   = n_q;
  assign lpbk_out = lb_q;

  // R4: the two line flops never agree
  a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
    p_q != n_q);

  // R5: no activity on either output once the serializer is idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!p_q && !lb_q));

  // R11: mode frozen while a frame is in flight
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(mode_q));

  // R9: loopback parks the line
  a_r9_loop_parks_line: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.loop |=> !p_q);

endmodule

// File: rtl/eth10_tx_phy.sv
module eth10_tx_phy
  import eth10_pkg::*;
#(
  parameter int DIBIT_CYC = 10,
  parameter int PRE_BITS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic [1:0] txd,
  input  logic [4:0] phy_addr,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       line_p,
  output logic       line_n,
  output logic       lpbk_out
);

  tx_mode_t cfg;
  logic     active, bit_val, first_half;

  eth10_mdio_slave #(
    .PRE_BITS(PRE_BITS)
  ) u_mgmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .phy_addr(phy_addr),
    .mdc     (mdc),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .cfg     (cfg)
  );

  eth10_serializer #(
    .DIBIT_CYC(DIBIT_CYC)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .txd       (txd),
    .active    (active),
    .bit_val   (bit_val),
    .first_half(first_half)
  );

  eth10_line_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .active    (active),
    .bit_val   (bit_val),
    .first_half(first_half),
    .cfg       (cfg),
    .line_p    (line_p),
    .line_n    (line_n),
    .lpbk_out  (lpbk_out)
  );

endmodule

// File: tb/tb_eth10_tx_phy.sv
module tb_eth10_tx_phy;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] txd = 2'b00;
  logic [4:0] phy_addr = 5'd3;
  logic       mdc = 1'b0;
  logic       mdio_i = 1'b1;
  logic       mdio_o, mdio_oe, line_p, line_n, lpbk_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  eth10_tx_phy dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .phy_addr(phy_addr),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .line_p(line_p), .line_n(line_n), .lpbk_out(lpbk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // expected stream value for one bit slot cycle
  function automatic bit exp_stream(input bit b, input int sub, input bit byp);
    if (byp) return b;
    return (sub < 3) ? ~b : b;
  endfunction

  // drive one frame and check every output cycle against mode (loop, byp)
  task automatic send_frame(input int n, input bit loop, input bit byp, input int mode);
    logic [1:0] d[0:127];
    for (int i = 0; i < n; i++) begin
      if (mode == 1) d[i] = 2'(i);
      else d[i] = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    tx_en = 1'b1;
    txd = d[0];
    for (int m = 0; m <= 10 * n + 1; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m >= 1 && m <= 10 * n) begin
        int p = m - 1;
        int k = p / 10;
        int ph = p % 10;
        bit b = (ph < 5) ? d[k][0] : d[k][1];
        bit s = exp_stream(b, ph % 5, byp);
        if (byp) chk(line_p == (loop ? 1'b0 : s), "R10", line_p, loop ? 0 : s);
        else     chk(line_p == (loop ? 1'b0 : s), "R3", line_p, loop ? 0 : s);
        chk(lpbk_out == (loop ? s : 1'b0), "R9", lpbk_out, loop ? s : 0);
      end
      chk(line_n == ~line_p, "R4", line_n, ~line_p);
      if (m % 10 == 9) begin
        int nk = m / 10 + 1;
        if (nk < n) txd = d[nk];
        else tx_en = 1'b0;
      end
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(line_p == 1'b0 && lpbk_out == 1'b0, "R5", {line_p, lpbk_out}, 0);
      chk(line_n == 1'b1, "R4", line_n, 1);
    end
  endtask

  task automatic mdc_cycle(input bit b, output bit o_s, output bit oe_s);
    mdc = 1'b0;
    mdio_i = b;
    repeat (8) @(negedge clk);
    o_s = mdio_o;
    oe_s = mdio_oe;
    mdc = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic mdio_hdr(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                          output bit any_oe);
    bit o, oe;
    logic [11:0] h;
    any_oe = 0;
    h = {op, pa, ra};
    for (int i = 0; i < 32; i++) begin mdc_cycle(1'b1, o, oe); any_oe |= oe; end
    mdc_cycle(1'b0, o, oe); any_oe |= oe;
    mdc_cycle(1'b1, o, oe); any_oe |= oe;
    for (int i = 11; i >= 0; i--) begin mdc_cycle(h[i], o, oe); any_oe |= oe; end
  endtask

  task automatic mdio_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    bit o, oe, any;
    mdio_hdr(2'b01, pa, ra, any);
    mdc_cycle(1'b1, o, oe); any |= oe;
    mdc_cycle(1'b0, o, oe); any |= oe;
    for (int i = 15; i >= 0; i--) begin mdc_cycle(v[i], o, oe); any |= oe; end
    mdc_cycle(1'b1, o, oe); any |= oe;
    chk(!any, "R6", any, 0);
  endtask

  task automatic mdio_read(input logic [4:0] pa, input logic [4:0] ra, input bit expect_drive,
                           output logic [15:0] v);
    bit o, oe, any;
    mdio_hdr(2'b10, pa, ra, any);
    chk(!any, "R7", any, 0);
    v = '0;
    mdc_cycle(1'b1, o, oe);
    chk(!oe, "R7", oe, 0);
    mdc_cycle(1'b1, o, oe);
    if (expect_drive) chk(oe && !o, "R7", {oe, o}, 2);
    else chk(!oe, "R8", oe, 0);
    for (int i = 15; i >= 0; i--) begin
      mdc_cycle(1'b1, o, oe);
      v[i] = o;
      if (expect_drive) chk(oe, "R7", oe, 1);
      else chk(!oe, "R8", oe, 0);
    end
    mdc_cycle(1'b1, o, oe);
    chk(!oe, "R7", oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(line_p == 0 && line_n == 1 && lpbk_out == 0 && mdio_oe == 0, "R1",
        {line_p, line_n, lpbk_out, mdio_oe}, 4'b0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3 directed dibit pattern 0,1,2,3
    send_frame(4, 0, 0, 1);
    // R2/R3 random frames
    for (int f = 0; f < 4; f++) send_frame($urandom_range(1, 20), 0, 0, 0);

    // R8 foreign address write ignored
    mdio_write(5'd9, 5'd0, 16'h4000);
    mdio_read(5'd3, 5'd0, 1, rv);
    chk(rv == 16'h0000, "R8", rv, 0);
    mdio_read(5'd9, 5'd0, 0, rv);
    send_frame(3, 0, 0, 0);

    // R6/R7/R9 loopback via control register
    mdio_write(5'd3, 5'd0, 16'hFFFF);
    mdio_read(5'd3, 5'd0, 1, rv);
    chk(rv == 16'h4000, "R7", rv, 16'h4000);
    mdio_read(5'd3, 5'd5, 1, rv);
    chk(rv == 16'h0000, "R7", rv, 0);
    send_frame(6, 1, 0, 0);

    // R6/R10 bypass via vendor register
    mdio_write(5'd3, 5'd0, 16'h0000);
    mdio_write(5'd3, 5'd16, 16'h0001);
    mdio_read(5'd3, 5'd16, 1, rv);
    chk(rv == 16'h0001, "R6", rv, 1);
    send_frame(5, 0, 1, 0);

    // R11 mode written mid-frame applies to the next frame only
    fork
      send_frame(120, 0, 1, 0);
      begin
        repeat (20) @(negedge clk);
        mdio_write(5'd3, 5'd16, 16'h0000);
      end
    join
    send_frame(4, 0, 0, 0);
    chk(1'b1, "R11", 1, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule